// File: doc/BRIEF.md
# Triangle Edge Walker with Rounding

This block steps down a triangle one scan-line at a time and produces, for every line, the pixel span to fill. It is loaded in a single cycle with the start X and slope of three edges and with the top, middle-vertex and bottom Y values. One edge is the long edge, which runs the full height of the triangle. The other is the short edge, which is replaced by the third edge at the middle vertex. A facing flag tells which of the two is the left boundary, so spans always come out with X increasing.

For each line the walker rounds the left boundary up to a whole pixel and the right boundary down to a whole pixel. It reports how far, in sixteenths of a pixel, the left rounding moved the boundary, so that a downstream shader can correct its starting colour or depth. Spans pass through a two-entry queue to four scan-line workers. The worker is chosen by the low two bits of Y. As soon as a span is queued, the next line is computed for the next worker. A full queue stalls the walk without losing or reordering anything.

Top module: `tri_edge_walker`

## Requirements
- R1: A `start` pulse is accepted only while `busy` is low, and `busy` is high from the following cycle. A `start` pulse while `busy` is high has no effect on the current walk and adds no lines.
- R2: A walk emits exactly one span for each Y from `y_top` to `y_bot` inclusive, in increasing Y order, where `y_top` <= `y_bot`. After the span for `y_bot` is queued, `busy` returns low.
- R3: Edge positions are 27-bit unsigned fixed-point values with 12 integer and 15 fraction bits. A start X (12 integer, 4 subpixel bits) enters as start<<11. A slope is a 27-bit two's complement value in units of 2^-15 pixel and is added once per line. The edge position on line y is therefore start*2^11 + (y - first line)*slope, modulo 2^27.
- R4: The long edge uses `x_long`/`dx_long` on every line. The short edge uses `x_short`/`dx_short` for lines below `y_mid`, and `x_third` + (y - `y_mid`)*`dx_third` for lines at or after `y_mid`. This includes the case `y_top` == `y_mid`, where the third edge is used from the first line.
- R5: With `right_face` = 1 the long edge is the left boundary and the short edge the right. With `right_face` = 0 it is the other way round.
- R6: `ln_lx` is the left position rounded up to a whole pixel, modulo 4096. `ln_xerr` is bits 14:11 of (2^15 - f) mod 2^15, where f is the 15-bit fraction of the left position; it is 0 when the left position is a whole pixel.
- R7: `ln_rx` is the integer part of the right position, which is the position rounded down.
- R8: `ln_empty` is 1 exactly when the rounded-up left value (13 bits, no wrap) exceeds the rounded-down right value. Such a line is still emitted.
- R9: At most one bit of `ln_valid` is set, and it is bit `ln_y[1:0]`. The span fields are shared by all workers.
- R10: While the offered span is not accepted, `ln_valid` and all span fields hold. Up to two spans wait in the queue and the walk stalls without dropping or reordering lines.
- R11: After reset `busy` is low and `ln_valid` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load the triangle and begin walking |
| right_face | input | 1 | 1: long edge is the left boundary |
| x_long | input | 16 | Long edge start X, 12.4 |
| dx_long | input | 27 | Long edge slope per line, two's complement 2^-15 units |
| x_short | input | 16 | Short edge start X, 12.4 |
| dx_short | input | 27 | Short edge slope per line |
| x_third | input | 16 | Third edge X at `y_mid`, 12.4 |
| dx_third | input | 27 | Third edge slope per line |
| y_top | input | 12 | First line |
| y_mid | input | 12 | Line where the third edge takes over |
| y_bot | input | 12 | Last line |
| busy | output | 1 | Walk in progress |
| ln_valid | output | 4 | Per-worker span valid |
| ln_ready | input | 4 | Per-worker span ready |
| ln_y | output | 12 | Span line |
| ln_lx | output | 12 | First pixel of the span |
| ln_rx | output | 12 | Last pixel of the span |
| ln_xerr | output | 4 | Left rounding distance, sixteenths of a pixel |
| ln_empty | output | 1 | Span covers no pixels |

## Verification
The hardest case to reach from the ports is the walk stalled behind a full queue while the head worker keeps its ready low. Only in that state can the walker lose or repeat a line, or switch edges at the vertex out of step. The stimulus holds every ready low for tens of cycles after `start`, so both queue entries fill and the walker sits at a line near the vertex. While it is stalled, a second `start` with different edges is pulsed. The readies are then released in a pseudo-random pattern. Each released span is compared with its expected value, which is computed in closed form from the edge equations.

// File: rtl/edge_walk_pkg.sv
package edge_walk_pkg;
    localparam int XI_W  = 12;              // integer pixel bits
    localparam int XS_W  = 4;               // subpixel bits of a start value
    localparam int XF_W  = 11;              // extra slope fraction bits
    localparam int XIN_W = XI_W + XS_W;     // start value width
    localparam int XFR_W = XS_W + XF_W;     // full fraction width
    localparam int XA_W  = XIN_W + XF_W;    // accumulator width
    localparam int Y_W   = 12;

    typedef logic [XA_W-1:0] xacc_t;

    typedef struct packed {
        logic [Y_W-1:0]  y;
        logic [XI_W-1:0] lx;
        logic [XI_W-1:0] rx;
        logic [XS_W-1:0] xerr;
        logic            empty;
    } span_t;

    // Round left up, right down, and measure the left rounding distance.
    function automatic span_t make_span(input logic [Y_W-1:0] y,
                                        input xacc_t al, input xacc_t ar);
        span_t            s;
        logic [XFR_W-1:0] fr;
        logic [XFR_W-1:0] gap;
        logic [XI_W:0]    lc;
        logic [XI_W:0]    rf;
        fr    = al[XFR_W-1:0];
        gap   = '0 - fr;
        lc    = {1'b0, al[XA_W-1:XFR_W]} + (XI_W+1)'(fr != '0);
        rf    = {1'b0, ar[XA_W-1:XFR_W]};
        s.y     = y;
        s.lx    = lc[XI_W-1:0];
        s.rx    = rf[XI_W-1:0];
        s.xerr  = gap[XFR_W-1 -: XS_W];
        s.empty = (lc > rf);
        return s;
    endfunction
endpackage

// File: rtl/edge_acc.sv
module edge_acc
    import edge_walk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  xacc_t load_x,
    input  xacc_t load_d,
    input  logic  step,
    input  logic  swap,
    input  xacc_t swap_x,
    input  xacc_t swap_d,
    output xacc_t acc
);
    xacc_t slope;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            slope <= '0;
        end else if (load) begin
            acc   <= load_x;
            slope <= load_d;
        end else if (step) begin
            if (swap) begin
                acc   <= swap_x;
                slope <= swap_d;
            end else begin
                acc   <= acc + slope;
            end
        end
    end
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
    import edge_walk_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [Y_W-1:0] y_top,
    input  logic [Y_W-1:0] y_mid,
    input  logic [Y_W-1:0] y_bot,
    input  logic           push_ok,
    output logic           busy,
    output logic           load,
    output logic           step,
    output logic           swap,
    output logic           push,
    output logic [Y_W-1:0] y
);
    typedef enum logic {ST_IDLE, ST_WALK} st_t;

    st_t            st;
    logic [Y_W-1:0] mid_r;
    logic [Y_W-1:0] bot_r;
    logic [Y_W-1:0] y_next;
    logic           last;

    assign busy   = (st == ST_WALK);
    assign load   = start && (st == ST_IDLE);
    assign push   = busy && push_ok;
    assign last   = (y == bot_r);
    assign step   = push && !last;
    assign y_next = y + 1'b1;
    assign swap   = (y_next == mid_r);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            y     <= '0;
            mid_r <= '0;
            bot_r <= '0;
        end else if (load) begin
            st    <= ST_WALK;
            y     <= y_top;
            mid_r <= y_mid;
            bot_r <= y_bot;
        end else if (push) begin
            if (last) st <= ST_IDLE;
            else      y  <= y_next;
        end
    end
endmodule

// File: rtl/span_fifo.sv
module span_fifo
    import edge_walk_pkg::*;
#(
    parameter  int DEPTH = 2,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  span_t din,
    output logic  full,
    input  logic  pop,
    output span_t dout,
    output logic  nonempty
);
    span_t           mem [DEPTH];
    logic [PW-1:0]   wp;
    logic [PW-1:0]   rp;
    logic [CW-1:0]   cnt;
    logic            do_push;
    logic            do_pop;

    assign full     = (cnt == CW'(DEPTH));
    assign nonempty = (cnt != '0);
    assign dout     = mem[rp];
    assign do_push  = push && !full;
    assign do_pop   = pop && nonempty;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/tri_edge_walker.sv
module tri_edge_walker
    import edge_walk_pkg::*;
#(
    parameter  int NWORK  = 4,
    parameter  int FIFO_D = 2,
    localparam int WSEL_W = $clog2(NWORK)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             right_face,
    input  logic [XIN_W-1:0] x_long,
    input  logic [XA_W-1:0]  dx_long,
    input  logic [XIN_W-1:0] x_short,
    input  logic [XA_W-1:0]  dx_short,
    input  logic [XIN_W-1:0] x_third,
    input  logic [XA_W-1:0]  dx_third,
    input  logic [Y_W-1:0]   y_top,
    input  logic [Y_W-1:0]   y_mid,
    input  logic [Y_W-1:0]   y_bot,
    output logic             busy,
    output logic [NWORK-1:0] ln_valid,
    input  logic [NWORK-1:0] ln_ready,
    output logic [Y_W-1:0]   ln_y,
    output logic [XI_W-1:0]  ln_lx,
    output logic [XI_W-1:0]  ln_rx,
    output logic [XS_W-1:0]  ln_xerr,
    output logic             ln_empty
);
    logic           load, step, swap, push, full, pop, nonempty;
    logic [Y_W-1:0] y;
    logic           face_r;
    xacc_t          third_x_r, third_d_r;
    xacc_t          a_long, a_short;
    xacc_t          short_x0, short_d0;
    span_t          span_in, head;
    logic           vtx_at_top;

    walk_ctrl u_ctrl (
        .clk, .rst, .start, .y_top, .y_mid, .y_bot,
        .push_ok(!full), .busy, .load, .step, .swap, .push, .y
    );

    // Holding registers for the edge that takes over at the middle vertex.
    always_ff @(posedge clk) begin
        if (rst) begin
            face_r    <= 1'b0;
            third_x_r <= '0;
            third_d_r <= '0;
        end else if (load) begin
            face_r    <= right_face;
            third_x_r <= {x_third, {XF_W{1'b0}}};
            third_d_r <= dx_third;
        end
    end

    assign vtx_at_top = (y_top == y_mid);
    assign short_x0   = vtx_at_top ? {x_third, {XF_W{1'b0}}} : {x_short, {XF_W{1'b0}}};
    assign short_d0   = vtx_at_top ? dx_third : dx_short;

    edge_acc u_long (
        .clk, .rst, .load, .load_x({x_long, {XF_W{1'b0}}}), .load_d(dx_long),
        .step, .swap(1'b0), .swap_x('0), .swap_d('0), .acc(a_long)
    );

    edge_acc u_short (
        .clk, .rst, .load, .load_x(short_x0), .load_d(short_d0),
        .step, .swap, .swap_x(third_x_r), .swap_d(third_d_r), .acc(a_short)
    );

    assign span_in = face_r ? make_span(y, a_long, a_short)
                            : make_span(y, a_short, a_long);

    span_fifo #(.DEPTH(FIFO_D)) u_fifo (
        .clk, .rst, .push, .din(span_in), .full, .pop, .dout(head), .nonempty
    );

    // Worker steering by the low Y bits of the queue head.
    for (genvar k = 0; k < NWORK; k++) begin : g_steer
        assign ln_valid[k] = nonempty && (head.y[WSEL_W-1:0] == WSEL_W'(k));
    end

    assign pop      = nonempty && ln_ready[head.y[WSEL_W-1:0]];
    assign ln_y     = head.y;
    assign ln_lx    = head.lx;
    assign ln_rx    = head.rx;
    assign ln_xerr  = head.xerr;
    assign ln_empty = head.empty;
endmodule

// File: rtl/edge_walk_chk.sv
module edge_walk_chk
    import edge_walk_pkg::*;
#(
    parameter  int NWORK  = 4,
    localparam int WSEL_W = $clog2(NWORK)
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic [NWORK-1:0] ln_valid,
    input logic [NWORK-1:0] ln_ready,
    input logic [Y_W-1:0]   ln_y,
    input logic [XI_W-1:0]  ln_lx,
    input logic [XI_W-1:0]  ln_rx,
    input logic [XS_W-1:0]  ln_xerr,
    input logic             ln_empty
);
    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));                                      // R1

    AST_ONE_WORKER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ln_valid));                                                // R9

    AST_WORKER_BY_Y: assert property (@(posedge clk) disable iff (rst)
        (ln_valid != '0) |-> ln_valid[ln_y[WSEL_W-1:0]]);                   // R9

    AST_SPAN_ORDERED: assert property (@(posedge clk) disable iff (rst)
        ((ln_valid != '0) && !ln_empty) |-> (ln_lx <= ln_rx));              // R8

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
        ((ln_valid != '0) && ((ln_valid & ln_ready) == '0)) |=>
        ($stable(ln_valid) && $stable(ln_y) && $stable(ln_lx) &&
         $stable(ln_rx) && $stable(ln_xerr) && $stable(ln_empty)));        // R10
endmodule

bind tri_edge_walker edge_walk_chk #(.NWORK(NWORK)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .ln_valid(ln_valid), .ln_ready(ln_ready), .ln_y(ln_y),
    .ln_lx(ln_lx), .ln_rx(ln_rx), .ln_xerr(ln_xerr), .ln_empty(ln_empty)
);

// File: tb/tb_tri_edge_walker.sv
`timescale 1ns/1ps
module tb_tri_edge_walker;
    import edge_walk_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             right_face = 1'b0;
    logic [XIN_W-1:0] x_long = '0, x_short = '0, x_third = '0;
    logic [XA_W-1:0]  dx_long = '0, dx_short = '0, dx_third = '0;
    logic [Y_W-1:0]   y_top = '0, y_mid = '0, y_bot = '0;
    logic             busy;
    logic [3:0]       ln_valid;
    logic [3:0]       ln_ready = '0;
    logic [Y_W-1:0]   ln_y;
    logic [XI_W-1:0]  ln_lx, ln_rx;
    logic [XS_W-1:0]  ln_xerr;
    logic             ln_empty;

    tri_edge_walker dut (.*);

    always #2 clk = ~clk;   // 250 MHz

    typedef struct { int y; int lx; int rx; int xerr; int empty; } exp_t;
    exp_t q[$];

    int   n_chk = 0, n_bad = 0, cycles = 0;
    int   rdy_mode = 2;      // 0 random, 1 all low, 2 all high
    logic [7:0] lfsr = 8'hA5;

    localparam longint AMASK = (64'd1 << 27) - 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint pos_at(longint xs, longint d, longint n);
        return ((xs <<< 11) + n * d) & AMASK;
    endfunction

    task automatic add_line(input int y, input longint al, input longint ar);
        exp_t   e;
        longint fr, lc, rf;
        fr = al & 32767;
        lc = (al >>> 15) + ((fr != 0) ? 1 : 0);
        rf = ar >>> 15;
        e.y     = y;
        e.lx    = int'(lc & 4095);
        e.rx    = int'(rf);
        e.xerr  = (fr == 0) ? 0 : int'((32768 - fr) >>> 11);
        e.empty = (lc > rf) ? 1 : 0;
        q.push_back(e);
    endtask

    task automatic drive(input bit face, input longint xl, input longint dl,
                         input longint xs, input longint ds, input longint xt,
                         input longint dt, input int yt, input int ym, input int yb);
        right_face = face;
        x_long = xl[XIN_W-1:0]; dx_long  = dl[XA_W-1:0];
        x_short = xs[XIN_W-1:0]; dx_short = ds[XA_W-1:0];
        x_third = xt[XIN_W-1:0]; dx_third = dt[XA_W-1:0];
        y_top = yt[Y_W-1:0]; y_mid = ym[Y_W-1:0]; y_bot = yb[Y_W-1:0];
    endtask

    // Driver: expected spans from the closed-form edge equations, then start.
    task automatic run_tri(input bit face, input longint xl, input longint dl,
                           input longint xs, input longint ds, input longint xt,
                           input longint dt, input int yt, input int ym, input int yb);
        for (int y = yt; y <= yb; y++) begin
            longint al, as;
            al = pos_at(xl, dl, y - yt);
            as = (y >= ym) ? pos_at(xt, dt, y - ym) : pos_at(xs, ds, y - yt);
            if (face) add_line(y, al, as);   // R5 long edge on the left
            else      add_line(y, as, al);
        end
        @(negedge clk);
        drive(face, xl, dl, xs, ds, xt, dt, yt, ym, yb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R1 busy after start", busy, 1);
    endtask

    task automatic wait_done();
        while (busy || q.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
        check(busy == 1'b0, "R2 busy low after last line", busy, 0);
        check(ln_valid == 4'b0, "R2 no extra line", ln_valid, 0);
    endtask

    // Monitor: drives readies, then compares accepted spans just before the edge.
    initial begin
        forever begin
            @(negedge clk);
            case (rdy_mode)
                0: ln_ready = lfsr[3:0];
                1: ln_ready = 4'b0;
                default: ln_ready = 4'hF;
            endcase
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            #1;
            for (int k = 0; k < 4; k++) begin
                if (ln_valid[k] && ln_ready[k]) begin
                    exp_t e;
                    check(k == int'(ln_y[1:0]), "R9 worker index", k, int'(ln_y[1:0]));
                    if (q.size() == 0) begin
                        check(1'b0, "R2 unexpected line", int'(ln_y), -1);
                    end else begin
                        e = q.pop_front();
                        check(int'(ln_y) == e.y, "R2 R4 line order y", int'(ln_y), e.y);
                        check(int'(ln_lx) == e.lx, "R3 R4 R6 left x", int'(ln_lx), e.lx);
                        check(int'(ln_xerr) == e.xerr, "R6 xerr", int'(ln_xerr), e.xerr);
                        check(int'(ln_rx) == e.rx, "R3 R5 R7 right x", int'(ln_rx), e.rx);
                        check(int'(ln_empty) == e.empty, "R8 empty flag", int'(ln_empty), e.empty);
                    end
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R11 busy after reset", busy, 0);
        check(ln_valid == 4'b0, "R11 valid after reset", ln_valid, 0);

        // Right-facing, vertex midway, walked behind a full queue (R10, R4)
        rdy_mode = 1;
        run_tri(1'b1, 1605, -16384, 1600, 40960, 1680, -24576, 10, 14, 20);
        repeat (30) @(negedge clk);
        check(busy == 1'b1, "R10 walker stalled on full queue", busy, 1);
        check(ln_valid == 4'b0100, "R9 R10 head held for worker 2", ln_valid, 4);
        rdy_mode = 0;
        wait_done();

        // Left-facing; start while busy must be ignored (R1)
        rdy_mode = 1;
        run_tri(1'b0, 3200, 3277, 3200, -65536, 3105, 22938, 33, 36, 41);
        repeat (5) @(negedge clk);
        drive(1'b1, 4800, 32768, 4848, -32768, 0, 0, 100, 200, 106);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rdy_mode = 0;
        wait_done();

        // Third edge from the first line: y_top == y_mid (R4)
        run_tri(1'b1, 328, -2048, 7777, 12345, 975, -49152, 50, 50, 60);
        wait_done();

        // Single line, left rounds past right: empty, xerr 15 (R6 R8)
        rdy_mode = 2;
        run_tri(1'b1, 81, 0, 80, 0, 0, 0, 7, 9, 7);
        wait_done();

        // Crossing edges over several lines (R8), random readies
        rdy_mode = 0;
        run_tri(1'b1, 4800, 32768, 4848, -32768, 0, 0, 100, 200, 106);
        wait_done();

        // Left-facing with a late vertex and wrap of the worker index (R5 R9)
        run_tri(1'b0, 800, 12000, 640, -9000, 600, -3000, 253, 259, 270);
        wait_done();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule